// File: doc/BRIEF.md
# Two-Level Top-Down Page Table Walker

This block refills a translation buffer after a miss without help from software. Given the faulting virtual address and the physical base of the root table, it walks a two-level table from the root towards the leaves. It issues exactly two 32-bit reads at physical addresses over a request/valid-response port. It then presents the virtual page number and the leaf entry to the buffer's insert port for one cycle. Table accesses never go through translation, so a walk cannot itself miss.

The walk is a fixed sequence of seven steps. First it forms the root index from the address and adds it to the root base, then loads the root entry. It then forms the leaf index, adds it to the frame base taken from the root entry, and loads the leaf entry. The last step is the insert. Each step takes one cycle, and each load step also stretches by every cycle the memory takes to answer. An entry whose valid bit is clear ends the walk with a one-cycle fault pulse in place of the insert. A requester stalls on the busy output until it sees the insert pulse or the fault pulse.

Top module: `ptw_top`

## Requirements
- R1: While reset is asserted and after it is released, busy, the memory request, the insert pulse and the fault pulse are all low, and a start seen during reset launches no walk.
- R2: A start seen while idle is accepted; busy is high from the next cycle and stays high until the cycle the insert pulse or the fault pulse appears.
- R3: The first read goes to the root base plus the virtual address bits 31:22 multiplied by 4.
- R4: The second read goes to the root entry with bits 11:0 cleared, plus the virtual address bits 21:12 multiplied by 4.
- R5: A completed walk issues exactly two reads. While a request waits for its response, the request and its address stay steady.
- R6: With responses given in the cycle of the request, the insert pulse appears in the seventh cycle after the accepting edge. Each cycle of response delay adds one cycle.
- R7: The insert pulse lasts one cycle and carries the virtual address bits 31:12 as the page number and the leaf entry unchanged.
- R8: A root entry with bit 0 clear gives a one-cycle fault pulse in the cycle after its response, with busy already low. It issues no second read and no insert.
- R9: A leaf entry with bit 0 clear gives a one-cycle fault pulse in the cycle after its response and no insert.
- R10: A start while busy is ignored, and so are changes of the virtual address or root base inputs after acceptance. The walk completes with the values captured at acceptance, and one insert.
- R11: The insert pulse and the fault pulse never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Miss request, sampled while idle |
| vaddr_i | input | 32 | Faulting virtual address |
| root_base_i | input | 32 | Physical base of the root table |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | Read request, held until response |
| mem_addr_o | output | 32 | Physical read address |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read response data |
| ins_valid_o | output | 1 | One-cycle insert pulse |
| ins_vpn_o | output | 20 | Virtual page number to insert |
| ins_pte_o | output | 32 | Leaf entry to insert |
| fault_o | output | 1 | One-cycle invalid-entry pulse |

## Verification
The hardest case to reach is a second start, together with changed address and base inputs, that lands while a walk waits on a slow response. Only a walk held in that window shows whether the captured values, not the live inputs, form the leaf address. The stimulus table sets a separate delay for each of the two responses. One directed run raises start and rewrites both inputs in the load step of the root entry. The memory model answers only the two addresses the bench derives from the original inputs, so any use of the new values yields a fault or a wrong address.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IDX_ROOT,
        ST_ADD_ROOT,
        ST_LD_ROOT,
        ST_IDX_LEAF,
        ST_ADD_LEAF,
        ST_LD_LEAF,
        ST_INSERT
    } walk_state_e;

    localparam int unsigned NUM_LEVELS = 2;
endpackage

// File: rtl/ptw_index.sv
module ptw_index #(
    parameter int unsigned VA_W     = 32,
    parameter int unsigned LSB      = 12,
    parameter int unsigned IDX_W    = 10,
    parameter int unsigned ENT_LOG  = 2,
    parameter int unsigned OUT_W    = 32
) (
    input  logic [VA_W-1:0]  vaddr,
    output logic [OUT_W-1:0] offset
);
    localparam int unsigned SCALED_W = IDX_W + ENT_LOG;

    always_comb begin
        offset = '0;
        offset[SCALED_W-1:0] = {vaddr[LSB +: IDX_W], {ENT_LOG{1'b0}}};
    end
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned PAGE_SHIFT = 12
) (
    input  logic [DATA_W-1:0] entry,
    output logic              valid,
    output logic [DATA_W-1:0] frame_base
);
    always_comb begin
        valid      = entry[0];
        frame_base = {entry[DATA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    end
endmodule

// File: rtl/ptw_top.sv
module ptw_top #(
    parameter int unsigned VA_W       = 32,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned IDX_W      = 10,
    parameter int unsigned ENT_LOG    = 2,
    localparam int unsigned VPN_W     = VA_W - PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [VA_W-1:0]   vaddr_i,
    input  logic [DATA_W-1:0] root_base_i,
    output logic              busy_o,
    output logic              mem_req_o,
    output logic [DATA_W-1:0] mem_addr_o,
    input  logic              mem_rvalid_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              ins_valid_o,
    output logic [VPN_W-1:0]  ins_vpn_o,
    output logic [DATA_W-1:0] ins_pte_o,
    output logic              fault_o
);
    import ptw_pkg::*;

    typedef struct packed {
        walk_state_e       st;
        logic [VA_W-1:0]   va;
        logic [DATA_W-1:0] base;
        logic [DATA_W-1:0] off;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] pte;
        logic              fault;
    } walk_t;

    walk_t r_q, r_d;

    logic [DATA_W-1:0] lvl_off [NUM_LEVELS];
    logic              ent_valid;
    logic [DATA_W-1:0] ent_frame;

    // level 0 is the root index (upper field), level 1 the leaf index
    for (genvar lv = 0; lv < NUM_LEVELS; lv++) begin : g_index
        ptw_index #(
            .VA_W   (VA_W),
            .LSB    (PAGE_SHIFT + (NUM_LEVELS - 1 - lv) * IDX_W),
            .IDX_W  (IDX_W),
            .ENT_LOG(ENT_LOG),
            .OUT_W  (DATA_W)
        ) u_idx (
            .vaddr (r_q.va),
            .offset(lvl_off[lv])
        );
    end

    ptw_entry_decode #(
        .DATA_W    (DATA_W),
        .PAGE_SHIFT(PAGE_SHIFT)
    ) u_dec (
        .entry     (mem_rdata_i),
        .valid     (ent_valid),
        .frame_base(ent_frame)
    );

    always_comb begin
        r_d       = r_q;
        r_d.fault = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st   = ST_IDX_ROOT;
                    r_d.va   = vaddr_i;
                    r_d.base = root_base_i;
                end
            end
            ST_IDX_ROOT: begin
                r_d.off = lvl_off[0];
                r_d.st  = ST_ADD_ROOT;
            end
            ST_ADD_ROOT: begin
                r_d.addr = r_q.base + r_q.off;
                r_d.st   = ST_LD_ROOT;
            end
            ST_LD_ROOT: begin
                if (mem_rvalid_i) begin
                    if (!ent_valid) begin
                        r_d.fault = 1'b1;
                        r_d.st    = ST_IDLE;
                    end else begin
                        r_d.base = ent_frame;
                        r_d.st   = ST_IDX_LEAF;
                    end
                end
            end
            ST_IDX_LEAF: begin
                r_d.off = lvl_off[1];
                r_d.st  = ST_ADD_LEAF;
            end
            ST_ADD_LEAF: begin
                r_d.addr = r_q.base + r_q.off;
                r_d.st   = ST_LD_LEAF;
            end
            ST_LD_LEAF: begin
                if (mem_rvalid_i) begin
                    if (!ent_valid) begin
                        r_d.fault = 1'b1;
                        r_d.st    = ST_IDLE;
                    end else begin
                        r_d.pte = mem_rdata_i;
                        r_d.st  = ST_INSERT;
                    end
                end
            end
            ST_INSERT: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        busy_o      = (r_q.st != ST_IDLE);
        mem_req_o   = (r_q.st == ST_LD_ROOT) || (r_q.st == ST_LD_LEAF);
        mem_addr_o  = r_q.addr;
        ins_valid_o = (r_q.st == ST_INSERT);
        ins_vpn_o   = r_q.va[VA_W-1:PAGE_SHIFT];
        ins_pte_o   = r_q.pte;
        fault_o     = r_q.fault;
    end
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned VA_W   = 32,
    parameter int unsigned VPN_W  = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [VA_W-1:0]   vaddr_i,
    input logic [DATA_W-1:0] root_base_i,
    input logic              busy_o,
    input logic              mem_req_o,
    input logic [DATA_W-1:0] mem_addr_o,
    input logic              mem_rvalid_i,
    input logic [DATA_W-1:0] mem_rdata_i,
    input logic              ins_valid_o,
    input logic [VPN_W-1:0]  ins_vpn_o,
    input logic [DATA_W-1:0] ins_pte_o,
    input logic              fault_o
);
    assert_idle_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !ins_valid_o) |=> (busy_o || fault_o));

    assert_req_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

    assert_ins_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid_o |=> !ins_valid_o);

    assert_ins_no_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid_o |-> (busy_o && !mem_req_o));

    assert_fault_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> !fault_o);

    assert_fault_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> !busy_o);

    assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ins_valid_o && fault_o));
endmodule

bind ptw_top ptw_checker #(
    .DATA_W(DATA_W),
    .VA_W  (VA_W),
    .VPN_W (VPN_W)
) u_chk (.*);

// File: tb/ptw_top_test.sv
module ptw_top_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [31:0] vaddr_i;
    logic [31:0] root_base_i;
    logic        busy_o;
    logic        mem_req_o;
    logic [31:0] mem_addr_o;
    logic        mem_rvalid_i;
    logic [31:0] mem_rdata_i;
    logic        ins_valid_o;
    logic [19:0] ins_vpn_o;
    logic [31:0] ins_pte_o;
    logic        fault_o;

    always #10 clk = ~clk;

    ptw_top uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vaddr_i(vaddr_i),
        .root_base_i(root_base_i), .busy_o(busy_o), .mem_req_o(mem_req_o),
        .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i),
        .mem_rdata_i(mem_rdata_i), .ins_valid_o(ins_valid_o),
        .ins_vpn_o(ins_vpn_o), .ins_pte_o(ins_pte_o), .fault_o(fault_o)
    );

    typedef struct packed {
        logic [31:0] va;
        logic [31:0] rb;
        logic [31:0] rpte;
        logic [31:0] lpte;
        logic [3:0]  lat1;
        logic [3:0]  lat2;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{32'h0040_3ABC, 32'h0010_0000, 32'h0020_0001, 32'h1234_5007, 4'd0, 4'd0},
        '{32'hFFFF_F123, 32'h0030_0000, 32'h0040_0FFF, 32'hABCD_E001, 4'd2, 4'd3},
        '{32'h0000_0000, 32'h0050_0000, 32'h0060_0003, 32'h0000_1001, 4'd1, 4'd0},
        '{32'h8000_1000, 32'h0010_0000, 32'h0070_0000, 32'h0000_0001, 4'd1, 4'd0},
        '{32'h1234_5678, 32'h0010_0000, 32'h0080_0001, 32'h9999_9000, 4'd0, 4'd2},
        '{32'h7FC0_0FFF, 32'h00A0_0000, 32'h00B0_1001, 32'h5555_5001, 4'd0, 4'd1}
    };

    int checks   = 0;
    int failures = 0;
    int cyc      = 0;

    // memory model state
    logic [31:0] exp_root, exp_leaf, cur_rpte, cur_lpte;
    int          lat1, lat2, reads, wcnt, cur_lat;
    bit          new_req = 1'b1;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // responding memory: answers only the two addresses derived from the requirements
    always @(negedge clk) begin
        if (!mem_req_o) begin
            mem_rvalid_i = 1'b0;
            wcnt         = 0;
            new_req      = 1'b1;
        end else begin
            if (new_req) begin
                new_req = 1'b0;
                reads++;
                cur_lat = (reads == 1) ? lat1 : lat2;
                if (reads == 1) check(mem_addr_o == exp_root, "R3 root address", mem_addr_o, exp_root);
                else            check(mem_addr_o == exp_leaf, "R4 leaf address", mem_addr_o, exp_leaf);
            end
            check(mem_req_o === 1'b1, "R5 request held", {31'b0, mem_req_o}, 32'd1);
            if (wcnt >= cur_lat) begin
                mem_rvalid_i = 1'b1;
                mem_rdata_i  = (mem_addr_o == exp_root) ? cur_rpte :
                               (mem_addr_o == exp_leaf) ? cur_lpte : 32'hDEAD_0000;
            end else begin
                mem_rvalid_i = 1'b0;
                wcnt++;
            end
        end
    end

    task automatic run_walk(input vec_t v, input bit poke);
        int  n = 0;
        int  got_n = 0;
        int  ins_cnt = 0;
        bit  flt = 1'b0;
        bit  done = 1'b0;
        bit  exp_fault;
        int  exp_n;
        int  exp_reads;
        exp_root = v.rb + {20'b0, v.va[31:22], 2'b00};
        exp_leaf = {v.rpte[31:12], 12'b0} + {20'b0, v.va[21:12], 2'b00};
        cur_rpte = v.rpte;
        cur_lpte = v.lpte;
        lat1     = int'(v.lat1);
        lat2     = int'(v.lat2);
        reads    = 0;
        exp_fault = !v.rpte[0] || !v.lpte[0];
        exp_n     = !v.rpte[0] ? 4 + lat1 : 7 + lat1 + lat2;
        exp_reads = !v.rpte[0] ? 1 : 2;
        @(negedge clk);
        start_i     = 1'b1;
        vaddr_i     = v.va;
        root_base_i = v.rb;
        @(posedge clk);
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                start_i = 1'b0;
                check(busy_o === 1'b1, "R2 busy after accept", {31'b0, busy_o}, 32'd1);
            end
            if (poke && n == 3) begin
                start_i     = 1'b1;
                vaddr_i     = ~v.va;
                root_base_i = 32'h00F0_0000;
            end else if (poke && n == 4) begin
                start_i = 1'b0;
            end
            if (ins_valid_o) begin
                ins_cnt++;
                got_n = n;
                done  = 1'b1;
                check(ins_vpn_o == v.va[31:12], "R7 page number", {12'b0, ins_vpn_o}, {12'b0, v.va[31:12]});
                check(ins_pte_o == v.lpte, "R7 leaf entry", ins_pte_o, v.lpte);
                check(fault_o == 1'b0, "R11 exclusive", {31'b0, fault_o}, 32'd0);
            end
            if (fault_o) begin
                flt   = 1'b1;
                got_n = n;
                done  = 1'b1;
                check(busy_o == 1'b0, "R8 busy low at fault", {31'b0, busy_o}, 32'd0);
            end
        end
        start_i = 1'b0;
        if (!v.rpte[0])      check(flt == exp_fault, "R8 root fault", {31'b0, flt}, {31'b0, exp_fault});
        else if (!v.lpte[0]) check(flt == exp_fault, "R9 leaf fault", {31'b0, flt}, {31'b0, exp_fault});
        else                 check(ins_cnt == 1, "R10 single insert", ins_cnt, 1);
        check(got_n == exp_n, "R6 walk cycles", got_n, exp_n);
        check(reads == exp_reads, "R5 read count", reads, exp_reads);
        @(negedge clk);
        check(!busy_o && !ins_valid_o && !fault_o && !mem_req_o, "R7 pulses end",
              {28'b0, busy_o, ins_valid_o, fault_o, mem_req_o}, 32'd0);
    endtask

    initial begin
        rst_n       = 1'b0;
        start_i     = 1'b1;
        vaddr_i     = 32'h0040_3ABC;
        root_base_i = 32'h0010_0000;
        mem_rvalid_i = 1'b0;
        mem_rdata_i  = 32'h0;
        repeat (3) @(negedge clk);
        check(!busy_o && !mem_req_o && !ins_valid_o && !fault_o, "R1 reset outputs",
              {28'b0, busy_o, mem_req_o, ins_valid_o, fault_o}, 32'd0);
        start_i = 1'b0;
        rst_n   = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy_o && !mem_req_o, "R1 idle after reset", {30'b0, busy_o, mem_req_o}, 32'd0);

        for (int i = 0; i < 6; i++) run_walk(VECS[i], 1'b0);

        // start and input changes during a slow root load
        run_walk('{32'h0040_3ABC, 32'h0010_0000, 32'h0020_0001, 32'h1234_5007, 4'd4, 4'd1}, 1'b1);

        // reset in the middle of a walk returns to idle
        @(negedge clk);
        start_i = 1'b1; vaddr_i = 32'h0040_3ABC; root_base_i = 32'h0010_0000;
        lat1 = 8; reads = 0;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy_o && !mem_req_o && !ins_valid_o && !fault_o, "R1 mid-walk reset",
              {28'b0, busy_o, mem_req_o, ins_valid_o, fault_o}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy_o, "R1 stays idle", {31'b0, busy_o}, 32'd0);

        run_walk(VECS[0], 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule